// File: doc/BRIEF.md
# Ethernet DMA Descriptor Ring Walker

This block steps through a ring of DMA descriptors held in shared memory on behalf of an Ethernet transmit or receive engine. After a kick strobe it reads the current descriptor over a simple request/acknowledge memory port. If the CPU has handed the descriptor to the hardware, the block reads the buffer pointer and passes the address and length to a data mover. When the mover reports completion, the block writes the descriptor back with ownership returned to the CPU and the completed length filled in. It then moves to the next descriptor. The payload itself never passes through this block.

The ring has no fixed size. Each descriptor is 16 bytes, placed at `ring_base + index*16`. A flag in the descriptor marks the last entry, and after that entry the walk restarts at index 0. The walker keeps going on its own for as long as it finds descriptors owned by the hardware. It goes idle at the first descriptor still owned by the CPU and waits there for the next kick. A buffer pointer that is not word aligned is treated as fatal: the walker stops and raises an error flag.

Top module: `dring_walker`

## Requirements
- R1: After reset, `mem_req`, `mov_req`, `busy`, `err_align` and `dsc_done` are low and the ring index is 0.
- R2: A memory request holds `mem_req`, `mem_addr` and `mem_we` unchanged until the cycle in which `mem_ack` is high. Read data is taken in that cycle.
- R3: A kick while idle reads descriptor word 0 at `ring_base + index*16`. If its ownership bit (bit 31) is 0, the walker returns to idle with no write and no mover request, and the next kick reads the same descriptor again.
- R4: For an owned descriptor, the walker reads word 1 (byte offset 4) as the buffer address and passes it to the mover. It then writes word 0 in a single write: bit 31 = 0, bit 30 = the end-of-ring flag read earlier, bits 15:0 = `mov_dlen`, and all other bits zero. Word 1 is never written.
- R5: If bit 30 of word 0 was set, the next descriptor is index 0. Otherwise it is the index plus one.
- R6: After a writeback, the walker reads the next descriptor without a kick. It continues until it finds one that the hardware does not own.
- R7: The length in bits 15:0 of word 0 goes to `mov_len`, capped at 1536 bytes.
- R8: A buffer address with bits 1:0 not zero raises `err_align`. That descriptor gets no mover request and no writeback. The walker then ignores kicks and issues nothing until reset.
- R9: `mov_req` stays high until `mov_done`, and `mov_req` and `mem_req` are never high together.
- R10: `dsc_done` is a single-cycle pulse, high in the cycle after the writeback is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_base | input | ADDR_W | Byte address of descriptor 0 |
| kick | input | 1 | Poll strobe, acted on only when idle |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | ADDR_W | Byte address of the word being accessed |
| mem_wdata | output | 32 | Writeback word |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Access complete |
| mov_req | output | 1 | Buffer transfer request |
| mov_addr | output | ADDR_W | Buffer address |
| mov_len | output | LEN_W | Buffer length after the cap |
| mov_done | input | 1 | Transfer complete |
| mov_dlen | input | LEN_W | Bytes actually transferred |
| dsc_done | output | 1 | Descriptor completed pulse |
| err_align | output | 1 | Misaligned buffer, walker halted |
| busy | output | 1 | Walk in progress |

## Verification
Each memory access completes on the edge at which the design samples `mem_ack` high. The monitor checks every falling edge at which a request waited without an acknowledge, and confirms that the next falling edge shows the same address and direction. `dsc_done` is due exactly one falling edge after the edge at which the writeback acknowledge was visible, and the monitor compares it on every such edge. The ownership decision, the pointer advance and the halt on a bad address are all settled before `busy` falls. The bench therefore waits for `busy` to drop after each kick and only then compares memory and the mover log against its model of the ring. The halt is also checked ten cycles after a later kick, to show that no request was issued.

// File: rtl/dw_pkg.sv
`timescale 1ns/1ps
package dw_pkg;
   localparam int OWN_BIT = 31;
   localparam int EOR_BIT = 30;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD0,
      ST_RD1,
      ST_CHK,
      ST_MOVE,
      ST_WB,
      ST_HALT
   } dw_state_e;
endpackage

// File: rtl/dw_ring_ptr.sv
`timescale 1ns/1ps
// Ring index register and descriptor word address generation.
module dw_ring_ptr #(
   parameter int ADDR_W    = 32,
   parameter int IDX_W     = 12,
   parameter int STRIDE_LG = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] ring_base,
   input  logic              adv,
   input  logic              wrap,
   input  logic              word_sel,
   output logic [ADDR_W-1:0] addr
);
   logic [IDX_W-1:0] idx_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         idx_q <= '0;
      else if (adv)
         idx_q <= wrap ? '0 : idx_q + IDX_W'(1);
   end

   assign addr = ring_base + (ADDR_W'(idx_q) << STRIDE_LG)
                 + (word_sel ? ADDR_W'(4) : '0);
endmodule

// File: rtl/dw_desc_decode.sv
`timescale 1ns/1ps
// Length capping and buffer alignment check.
module dw_desc_decode #(
   parameter int ADDR_W    = 32,
   parameter int LEN_W     = 16,
   parameter int BUF_BYTES = 1536,
   parameter int ALIGN_LG  = 2,
   parameter bit CLAMP_EN  = 1'b1
) (
   input  logic [LEN_W-1:0]  raw_len,
   input  logic [ADDR_W-1:0] raw_addr,
   output logic [LEN_W-1:0]  xfer_len,
   output logic [ADDR_W-1:0] buf_addr,
   output logic              misaligned
);
   assign buf_addr = raw_addr;

   generate
      if (CLAMP_EN) begin : g_clamp
         localparam logic [LEN_W-1:0] CAP = LEN_W'(BUF_BYTES);
         assign xfer_len = (raw_len > CAP) ? CAP : raw_len;
      end else begin : g_pass
         assign xfer_len = raw_len;
      end

      if (ALIGN_LG > 0) begin : g_align
         assign misaligned = |raw_addr[ALIGN_LG-1:0];
      end else begin : g_noalign
         assign misaligned = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/dw_wb_format.sv
`timescale 1ns/1ps
// Builds the writeback word: ownership cleared, ring flag kept, status length.
module dw_wb_format import dw_pkg::*; #(
   parameter int LEN_W = 16
) (
   input  logic             eor,
   input  logic [LEN_W-1:0] dlen,
   output logic [31:0]      word
);
   always_comb begin
      word              = '0;
      word[LEN_W-1:0]   = dlen;
      word[EOR_BIT]     = eor;
      word[OWN_BIT]     = 1'b0;
   end
endmodule

// File: rtl/dring_walker.sv
`timescale 1ns/1ps
module dring_walker import dw_pkg::*; #(
   parameter int ADDR_W      = 32,
   parameter int LEN_W       = 16,
   parameter int IDX_W       = 12,
   parameter int DESC_WORDS  = 4,
   parameter int BUF_BYTES   = 1536,
   parameter int ALIGN_BYTES = 4,
   parameter bit CLAMP_EN    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] ring_base,
   input  logic              kick,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [31:0]       mem_wdata,
   input  logic [31:0]       mem_rdata,
   input  logic              mem_ack,
   output logic              mov_req,
   output logic [ADDR_W-1:0] mov_addr,
   output logic [LEN_W-1:0]  mov_len,
   input  logic              mov_done,
   input  logic [LEN_W-1:0]  mov_dlen,
   output logic              dsc_done,
   output logic              err_align,
   output logic              busy
);
   localparam int STRIDE_BYTES = DESC_WORDS * 4;
   localparam int STRIDE_LG    = $clog2(STRIDE_BYTES);
   localparam int ALIGN_LG     = $clog2(ALIGN_BYTES);

   generate
      if (ADDR_W > 32 || ADDR_W < IDX_W + STRIDE_LG) begin : g_bad_addr
         $error("dring_walker: ADDR_W out of range");
      end
      if (LEN_W > 28 || LEN_W < 1) begin : g_bad_len
         $error("dring_walker: LEN_W must be 1..28");
      end
      if ((1 << STRIDE_LG) != STRIDE_BYTES || DESC_WORDS < 2) begin : g_bad_stride
         $error("dring_walker: DESC_WORDS must be a power of two >= 2");
      end
      if ((1 << ALIGN_LG) != ALIGN_BYTES) begin : g_bad_align
         $error("dring_walker: ALIGN_BYTES must be a power of two");
      end
      if (BUF_BYTES >= (1 << LEN_W)) begin : g_bad_buf
         $error("dring_walker: BUF_BYTES does not fit LEN_W");
      end
   endgenerate

   dw_state_e         st_q, st_d;
   logic              eor_q;
   logic [LEN_W-1:0]  len_q;
   logic [LEN_W-1:0]  dlen_q;
   logic [ADDR_W-1:0] w1_q;
   logic              done_q;
   logic              adv;
   logic              word_sel;
   logic              misal;
   logic [LEN_W-1:0]  xfer_len;
   logic [ADDR_W-1:0] buf_addr;

   dw_ring_ptr #(
      .ADDR_W(ADDR_W), .IDX_W(IDX_W), .STRIDE_LG(STRIDE_LG)
   ) u_ptr (
      .clk(clk), .rst_n(rst_n), .ring_base(ring_base), .adv(adv),
      .wrap(eor_q), .word_sel(word_sel), .addr(mem_addr)
   );

   dw_desc_decode #(
      .ADDR_W(ADDR_W), .LEN_W(LEN_W), .BUF_BYTES(BUF_BYTES),
      .ALIGN_LG(ALIGN_LG), .CLAMP_EN(CLAMP_EN)
   ) u_dec (
      .raw_len(len_q), .raw_addr(w1_q), .xfer_len(xfer_len),
      .buf_addr(buf_addr), .misaligned(misal)
   );

   dw_wb_format #(.LEN_W(LEN_W)) u_wb (
      .eor(eor_q), .dlen(dlen_q), .word(mem_wdata)
   );

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE: if (kick) st_d = ST_RD0;
         ST_RD0:  if (mem_ack) st_d = mem_rdata[OWN_BIT] ? ST_RD1 : ST_IDLE;
         ST_RD1:  if (mem_ack) st_d = ST_CHK;
         ST_CHK:  st_d = misal ? ST_HALT : ST_MOVE;
         ST_MOVE: if (mov_done) st_d = ST_WB;
         ST_WB:   if (mem_ack) st_d = ST_RD0;
         ST_HALT: st_d = ST_HALT;
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         eor_q  <= 1'b0;
         len_q  <= '0;
         dlen_q <= '0;
         w1_q   <= '0;
         done_q <= 1'b0;
      end else begin
         st_q   <= st_d;
         done_q <= (st_q == ST_WB) && mem_ack;
         if (st_q == ST_RD0 && mem_ack) begin
            eor_q <= mem_rdata[EOR_BIT];
            len_q <= mem_rdata[LEN_W-1:0];
         end
         if (st_q == ST_RD1 && mem_ack)
            w1_q <= mem_rdata[ADDR_W-1:0];
         if (st_q == ST_MOVE && mov_done)
            dlen_q <= mov_dlen;
      end
   end

   assign mem_req   = (st_q == ST_RD0) || (st_q == ST_RD1) || (st_q == ST_WB);
   assign mem_we    = (st_q == ST_WB);
   assign word_sel  = (st_q == ST_RD1);
   assign adv       = (st_q == ST_WB) && mem_ack;
   assign mov_req   = (st_q == ST_MOVE);
   assign mov_addr  = buf_addr;
   assign mov_len   = xfer_len;
   assign dsc_done  = done_q;
   assign err_align = (st_q == ST_HALT);
   assign busy      = (st_q != ST_IDLE) && (st_q != ST_HALT);
endmodule

// File: rtl/dw_checker.sv
`timescale 1ns/1ps
module dw_checker #(
   parameter int ADDR_W      = 32,
   parameter int LEN_W       = 16,
   parameter int BUF_BYTES   = 1536,
   parameter int ALIGN_BYTES = 4,
   parameter bit CLAMP_EN    = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mem_req,
   input logic              mem_we,
   input logic              mem_ack,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              wb_own,
   input logic              mov_req,
   input logic [ADDR_W-1:0] mov_addr,
   input logic [LEN_W-1:0]  mov_len,
   input logic              dsc_done,
   input logic              err_align,
   input logic              busy
);
   localparam logic [ADDR_W-1:0] AMASK = ADDR_W'(ALIGN_BYTES - 1);

   a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

   a_r4_wb_own: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> !wb_own);

   a_r7_cap: assert property (@(posedge clk) disable iff (!rst_n)
      (mov_req && CLAMP_EN) |-> (mov_len <= LEN_W'(BUF_BYTES)));

   a_r8_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      mov_req |-> ((mov_addr & AMASK) == '0));

   a_r8_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      err_align |-> (!mem_req && !mov_req && !busy));

   a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      err_align |=> err_align);

   a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_req && mov_req));

   a_r10_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      dsc_done |=> !dsc_done);

   a_r10_after_wb: assert property (@(posedge clk) disable iff (!rst_n)
      dsc_done |-> $past(mem_req && mem_we && mem_ack));
endmodule

bind dring_walker dw_checker #(
   .ADDR_W(ADDR_W), .LEN_W(LEN_W), .BUF_BYTES(BUF_BYTES),
   .ALIGN_BYTES(ALIGN_BYTES), .CLAMP_EN(CLAMP_EN)
) u_chk (
   .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
   .mem_ack(mem_ack), .mem_addr(mem_addr), .wb_own(mem_wdata[31]),
   .mov_req(mov_req), .mov_addr(mov_addr), .mov_len(mov_len),
   .dsc_done(dsc_done), .err_align(err_align), .busy(busy)
);

// File: tb/sim_dring_walker.sv
`timescale 1ns/1ps
module sim_dring_walker;
   localparam int AW  = 32;
   localparam int LW  = 16;
   localparam int CAP = 1536;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] ring_base = 32'h100;
   logic          kick = 1'b0;
   logic          mem_req, mem_we, mem_ack;
   logic [AW-1:0] mem_addr;
   logic [31:0]   mem_wdata, mem_rdata;
   logic          mov_req, mov_done;
   logic [AW-1:0] mov_addr;
   logic [LW-1:0] mov_len, mov_dlen;
   logic          dsc_done, err_align, busy;

   always #2.5 clk = ~clk;

   dring_walker u0 (
      .clk(clk), .rst_n(rst_n), .ring_base(ring_base), .kick(kick),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
      .mov_req(mov_req), .mov_addr(mov_addr), .mov_len(mov_len),
      .mov_done(mov_done), .mov_dlen(mov_dlen), .dsc_done(dsc_done),
      .err_align(err_align), .busy(busy)
   );

   int checks = 0;
   int fails  = 0;

   task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s act=%h exp=%h", rq, act, exp);
      end
   endtask

   // ---------------- memory and mover models ----------------
   logic [31:0]   mem [0:255];
   int unsigned   mcnt, vcnt;
   int            wr_cnt;
   logic [AW-1:0] lg_addr [0:255];
   logic [LW-1:0] lg_len  [0:255];
   logic [LW-1:0] lg_dlen [0:255];
   int            lg_n;
   logic [LW-1:0] dtmp;

   always @(posedge clk) begin
      if (!rst_n) begin
         mem_ack <= 1'b0; mcnt <= 0; wr_cnt <= 0; mem_rdata <= '0;
      end else if (mem_ack) begin
         mem_ack <= 1'b0; mcnt <= $urandom % 3;
      end else if (mem_req) begin
         if (mcnt == 0) begin
            mem_ack <= 1'b1;
            if (mem_we) begin
               mem[mem_addr[9:2]] <= mem_wdata;
               wr_cnt <= wr_cnt + 1;
            end else
               mem_rdata <= mem[mem_addr[9:2]];
         end else
            mcnt <= mcnt - 1;
      end
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         mov_done <= 1'b0; vcnt <= 0; lg_n <= 0; mov_dlen <= '0;
      end else if (mov_done) begin
         mov_done <= 1'b0; vcnt <= $urandom % 4;
      end else if (mov_req) begin
         if (vcnt == 0) begin
            dtmp = mov_len - LW'($urandom % 4);
            mov_done <= 1'b1;
            mov_dlen <= dtmp;
            lg_addr[lg_n] <= mov_addr;
            lg_len[lg_n]  <= mov_len;
            lg_dlen[lg_n] <= dtmp;
            lg_n <= lg_n + 1;
         end else
            vcnt <= vcnt - 1;
      end
   end

   // ---------------- cycle monitor ----------------
   logic          exp_done = 1'b0;
   logic          prev_wait = 1'b0;
   logic [AW-1:0] prev_addr;
   logic          prev_we;
   int            done_cnt = 0;
   int            req_cycles = 0;

   always @(negedge clk) begin
      if (!rst_n) begin
         exp_done  = 1'b0;
         prev_wait = 1'b0;
      end else begin
         if (dsc_done || exp_done)
            chk(dsc_done == exp_done, "R10 done timing", 32'(dsc_done), 32'(exp_done));
         exp_done = mem_req && mem_we && mem_ack;
         if (prev_wait)
            chk(mem_req && mem_addr == prev_addr && mem_we == prev_we,
                "R2 request hold", mem_addr, prev_addr);
         prev_wait = mem_req && !mem_ack;
         prev_addr = mem_addr;
         prev_we   = mem_we;
         if (mem_req && mov_req)
            chk(1'b0, "R9 exclusive", 32'd1, 32'd0);
         if (dsc_done) done_cnt++;
         if (mem_req) req_cycles++;
      end
   end

   // ---------------- stimulus helpers ----------------
   logic [31:0] sh0 [0:7];
   logic [31:0] sh1 [0:7];

   function automatic logic [LW-1:0] capped(input logic [31:0] w0);
      return (w0[15:0] > CAP) ? LW'(CAP) : w0[15:0];
   endfunction

   task automatic put(input int bw, input int i, input logic [31:0] w0,
                      input logic [31:0] w1);
      sh0[i] = w0; sh1[i] = w1;
      mem[bw + 4*i]     = w0;
      mem[bw + 4*i + 1] = w1;
   endtask

   task automatic build_ring(input int bw, input int n, input int p, input int c);
      for (int i = 0; i < n; i++) begin
         int rel;
         logic [31:0] w0;
         rel = (i - p + n) % n;
         w0 = {(rel < c), (i == n-1), 14'h0, 16'($urandom_range(64, 2047))};
         put(bw, i, w0, $urandom & 32'hFFFF_FFFC);
      end
   endtask

   task automatic kick_wait();
      int g;
      @(negedge clk) kick = 1'b1;
      @(negedge clk) kick = 1'b0;
      g = 0;
      while (busy && g < 5000) begin
         @(negedge clk);
         g++;
      end
      if (g >= 5000) chk(1'b0, "R6 walk finished", 32'(g), 32'd0);
   endtask

   task automatic verify_round(input int bw, input int n, input int p,
                               input int c, input int lb, input int db);
      chk(lg_n - lb == c, "R6 mover calls", 32'(lg_n - lb), 32'(c));
      chk(done_cnt - db == c, "R10 done count", 32'(done_cnt - db), 32'(c));
      for (int k = 0; k < n; k++) begin
         int i;
         i = (p + k) % n;
         if (k < c && k < lg_n - lb) begin
            chk(lg_addr[lb+k] == sh1[i], "R5 order/buffer address", lg_addr[lb+k], sh1[i]);
            chk(lg_len[lb+k] == capped(sh0[i]), "R7 length cap",
                32'(lg_len[lb+k]), 32'(capped(sh0[i])));
            chk(mem[bw+4*i] == {1'b0, sh0[i][30], 14'h0, lg_dlen[lb+k]},
                "R4 writeback word", mem[bw+4*i], {1'b0, sh0[i][30], 14'h0, lg_dlen[lb+k]});
         end else if (k >= c) begin
            chk(mem[bw+4*i] == sh0[i], "R3 untouched descriptor", mem[bw+4*i], sh0[i]);
         end
         chk(mem[bw+4*i+1] == sh1[i], "R4 word1 kept", mem[bw+4*i+1], sh1[i]);
      end
   endtask

   task automatic do_reset(input logic [AW-1:0] base);
      rst_n = 1'b0;
      ring_base = base;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (150000) @(negedge clk);
      chk(1'b0, "R6 watchdog", 32'd1, 32'd0);
      summary();
   end

   // ---------------- main sequence ----------------
   initial begin
      int bw, p, lb, db, wb0, rq0;
      void'($urandom(32'd7741));
      for (int i = 0; i < 256; i++) mem[i] = '0;
      do_reset(32'h100);
      bw = 32'h100 >> 2;

      // R1 reset state
      chk(!mem_req, "R1 mem_req", 32'(mem_req), 0);
      chk(!mov_req, "R1 mov_req", 32'(mov_req), 0);
      chk(!busy, "R1 busy", 32'(busy), 0);
      chk(!err_align, "R1 err_align", 32'(err_align), 0);
      chk(!dsc_done, "R1 dsc_done", 32'(dsc_done), 0);

      // directed: three owned, cap corner lengths, wrap back to index 0
      build_ring(bw, 3, 0, 3);
      put(bw, 0, {2'b10, 14'h0, 16'd2000}, sh1[0]);
      put(bw, 1, {2'b10, 14'h0, 16'd1536}, sh1[1]);
      put(bw, 2, {2'b11, 14'h0, 16'd100},  sh1[2]);
      lb = lg_n; db = done_cnt;
      kick_wait();
      verify_round(bw, 3, 0, 3, lb, db);
      p = 0;

      // directed: not owned -> no effect, then refetch of same descriptor (R3)
      build_ring(bw, 3, p, 0);
      lb = lg_n; db = done_cnt; wb0 = wr_cnt;
      kick_wait();
      chk(wr_cnt == wb0, "R3 no write when not owned", 32'(wr_cnt), 32'(wb0));
      chk(lg_n == lb, "R3 no mover when not owned", 32'(lg_n), 32'(lb));
      put(bw, p, sh0[p] | 32'h8000_0000, sh1[p]);
      kick_wait();
      verify_round(bw, 3, p, 1, lb, db);
      p = (p + 1) % 3;

      // random rounds on a ring of five
      build_ring(bw, 5, 0, 0);
      for (int r = 0; r < 24; r++) begin
         int c;
         c = $urandom % 6;
         build_ring(bw, 5, p, c);
         lb = lg_n; db = done_cnt;
         kick_wait();
         verify_round(bw, 5, p, c, lb, db);
         p = (p + c) % 5;
      end

      // misaligned buffer halts the walker (R8), new ring base
      do_reset(32'h200);
      bw = 32'h200 >> 2;
      build_ring(bw, 3, 0, 2);
      put(bw, 1, sh0[1], sh1[1] | 32'h2);
      lb = lg_n; db = done_cnt;
      kick_wait();
      chk(err_align, "R8 error raised", 32'(err_align), 1);
      chk(!busy, "R8 not busy", 32'(busy), 0);
      chk(lg_n - lb == 1, "R8 no mover for bad desc", 32'(lg_n - lb), 1);
      chk(mem[bw+4] == sh0[1], "R8 bad desc not written", mem[bw+4], sh0[1]);
      chk(mem[bw] == {1'b0, sh0[0][30], 14'h0, lg_dlen[lb]}, "R4 first desc done",
          mem[bw], {1'b0, sh0[0][30], 14'h0, lg_dlen[lb]});
      rq0 = req_cycles;
      @(negedge clk) kick = 1'b1;
      @(negedge clk) kick = 1'b0;
      repeat (10) @(negedge clk);
      chk(req_cycles == rq0, "R8 kick ignored", 32'(req_cycles), 32'(rq0));
      chk(err_align && !mov_req, "R8 still halted", 32'(err_align), 1);

      // after reset the walker works again from index 0 (R1)
      do_reset(32'h200);
      build_ring(bw, 2, 0, 2);
      lb = lg_n; db = done_cnt;
      kick_wait();
      verify_round(bw, 2, 0, 2, lb, db);

      summary();
   end
endmodule